// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block supplies the instruction fetch address for a small microcontroller core whose instructions are 14 bits wide. It keeps a 13-bit program counter, which covers an 8K-word instruction space. It also keeps an eight-entry return stack in dedicated storage, separate from data memory. On every clock it chooses the next fetch address from the requests it is given. The possible sources are a plain step, a skip, a direct jump or call target, a return, an interrupt acceptance, and a data-path write to the low program-counter byte.

The upper program-counter bits are not written directly. Software first stores them in a five-bit high-address latch. They are then merged in when the low byte is written, which gives a computed jump. The two upper bits of that latch also extend the 11-bit target carried by jump and call instructions. The decode logic outside the block asserts at most one request per cycle in normal use. A fixed priority settles any overlap.

Top module: `pc_seq`

## Requirements
- R1: A cycle with `rst` high sets `fetch_addr` to 0000h and clears the high-address latch to 00000b.
- R2: With `step` as the only request, `fetch_addr` advances by 1, and 1FFFh wraps to 0000h.
- R3: With `skip` as the winning request, `fetch_addr` advances by 2 modulo 2^13 (1FFEh goes to 0000h, 1FFFh goes to 0001h).
- R4: `pcl_we` as the winning request loads `fetch_addr` with {latch[4:0], `pcl_wdata`[7:0]}.
- R5: `jump` loads `fetch_addr` with {latch[4:3], `target`[10:0]}.
- R6: `call` loads the same address as R5 and pushes `fetch_addr`+1 onto the return stack.
- R7: `ret` loads `fetch_addr` with the most recently pushed entry and pops it. The latch is not changed by a return.
- R8: `irq_ack` pushes the current `fetch_addr` and loads 0004h.
- R9: The stack is an eight-entry ring. A ninth push overwrites the oldest entry, with no overflow indication, so eight pops after nine calls return the addresses of calls nine down to two.
- R10: Priority, from highest to lowest: `irq_ack`, `ret`, `call`, `jump`, `pcl_we`, `skip`, `step`. With no request, `fetch_addr` holds its value.
- R11: `pcl_rd` always equals `fetch_addr`[7:0].
- R12: `lat_we` updates the latch at the clock edge. A low-byte write or jump in the same cycle uses the previous latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance to next sequential address |
| skip | input | 1 | Advance by two, discarding the next instruction |
| jump | input | 1 | Absolute jump to latch-extended target |
| call | input | 1 | Jump and push return address |
| target | input | 11 | Jump or call target from the instruction |
| ret | input | 1 | Pop return address into the counter |
| irq_ack | input | 1 | Interrupt accepted: push and go to 0004h |
| pcl_we | input | 1 | Data-path write of the low counter byte |
| pcl_wdata | input | 8 | Low byte write data |
| lat_we | input | 1 | Write enable for the high-address latch |
| lat_wdata | input | 5 | High-address latch write data |
| fetch_addr | output | 13 | Registered program counter / fetch address |
| pcl_rd | output | 8 | Readable low counter byte |

## Verification
Every request changes `fetch_addr` and `pcl_rd` at the first rising edge after it is applied, because the counter is the only register on that path. A latch write becomes visible one edge later, through the next low-byte write or jump. The bench drives inputs on falling edges and compares both outputs against its reference model at the following falling edge. It therefore samples each result exactly one clock after its stimulus. Return values are checked at that same point, so a push followed immediately by a pop exercises the stack write-then-read path with no gap between them.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_SKIP,
    OP_PCL,
    OP_JMP,
    OP_CALL,
    OP_RET,
    OP_IRQ
  } pc_op_e;
endpackage

// File: rtl/pcseq_arb.sv
module pcseq_arb
  import pcseq_pkg::*;
(
  input  logic   step,
  input  logic   skip,
  input  logic   pcl_we,
  input  logic   jump,
  input  logic   call,
  input  logic   ret,
  input  logic   irq_ack,
  output pc_op_e op
);
  // Fixed priority: interrupt, return, call, jump, low-byte write, skip, step
  always_comb begin
    if (irq_ack)     op = OP_IRQ;
    else if (ret)    op = OP_RET;
    else if (call)   op = OP_CALL;
    else if (jump)   op = OP_JMP;
    else if (pcl_we) op = OP_PCL;
    else if (skip)   op = OP_SKIP;
    else if (step)   op = OP_STEP;
    else             op = OP_HOLD;
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] top_idx;

  assign top_idx  = ptr - PTR_W'(1);
  assign top_data = mem[top_idx];

  // Storage has no reset, so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[ptr] <= push_data;
  end

  // Ring pointer: wraps silently in both directions
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (push) ptr <= ptr + PTR_W'(1);
    else if (pop)  ptr <= ptr - PTR_W'(1);
  end

  // R9: the entry just pushed is the one a pop would return
  a_r9_push_readback: assert property (@(posedge clk) disable iff (rst)
    push |=> top_data == $past(push_data));

  // R9: push and pop are never requested together by the arbiter
  a_r9_no_push_pop: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          TGT_W   = 11,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input  pc_op_e            op,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-9:0]   lat,
  input  logic [7:0]        pcl_wdata,
  input  logic [TGT_W-1:0]  target,
  input  logic [PC_W-1:0]   pop_data,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   push_data
);
  localparam int LAT_W = PC_W - 8;
  localparam int HI_W  = PC_W - TGT_W;

  logic [PC_W-1:0] seq1;
  logic [PC_W-1:0] seq2;
  logic [PC_W-1:0] far;

  assign seq1 = pc + PC_W'(1);
  assign seq2 = pc + PC_W'(2);
  assign far  = {lat[LAT_W-1 -: HI_W], target};

  always_comb begin
    unique case (op)
      OP_STEP: next_pc = seq1;
      OP_SKIP: next_pc = seq2;
      OP_PCL:  next_pc = {lat, pcl_wdata};
      OP_JMP,
      OP_CALL: next_pc = far;
      OP_RET:  next_pc = pop_data;
      OP_IRQ:  next_pc = IRQ_VEC[PC_W-1:0];
      default: next_pc = pc;
    endcase
  end

  // A call returns past itself; an interrupt returns to the preempted fetch
  assign push_data = (op == OP_CALL) ? seq1 : pc;
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcseq_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          TGT_W   = 11,
  parameter int          DEPTH   = 8,
  parameter logic [12:0] RST_VEC = 13'h0000,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              skip,
  input  logic              jump,
  input  logic              call,
  input  logic [TGT_W-1:0]  target,
  input  logic              ret,
  input  logic              irq_ack,
  input  logic              pcl_we,
  input  logic [7:0]        pcl_wdata,
  input  logic              lat_we,
  input  logic [PC_W-9:0]   lat_wdata,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [7:0]        pcl_rd
);
  localparam int LAT_W = PC_W - 8;

  pc_op_e            op;
  logic [PC_W-1:0]   pc;
  logic [LAT_W-1:0]  lat;
  logic [PC_W-1:0]   next_pc;
  logic [PC_W-1:0]   push_data;
  logic [PC_W-1:0]   pop_data;
  logic              push;
  logic              pop;

  pcseq_arb u_arb (
    .step    (step),
    .skip    (skip),
    .pcl_we  (pcl_we),
    .jump    (jump),
    .call    (call),
    .ret     (ret),
    .irq_ack (irq_ack),
    .op      (op)
  );

  assign push = (op == OP_CALL) || (op == OP_IRQ);
  assign pop  = (op == OP_RET);

  pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .top_data  (pop_data)
  );

  pcseq_next #(.PC_W(PC_W), .TGT_W(TGT_W), .IRQ_VEC(IRQ_VEC)) u_next (
    .op        (op),
    .pc        (pc),
    .lat       (lat),
    .pcl_wdata (pcl_wdata),
    .target    (target),
    .pop_data  (pop_data),
    .next_pc   (next_pc),
    .push_data (push_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= RST_VEC[PC_W-1:0];
    else     pc <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (rst)         lat <= '0;
    else if (lat_we) lat <= lat_wdata;
  end

  assign fetch_addr = pc;
  assign pcl_rd     = pc[7:0];

  // R1: reset lands on the reset vector
  a_r1_reset_vector: assert property (@(posedge clk)
    rst |=> fetch_addr == RST_VEC[PC_W-1:0]);

  // R8: interrupt acceptance always lands on the interrupt vector
  a_r8_irq_vector: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> fetch_addr == IRQ_VEC[PC_W-1:0]);

  // R3: skip advances the fetch address by two with wrap
  a_r3_skip_two: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SKIP) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(2)));

  // R4: low-byte write merges the latch above the written byte
  a_r4_pcl_merge: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PCL) |=> fetch_addr == {$past(lat), $past(pcl_wdata)});

  // R7: a return leaves the latch alone
  a_r7_ret_latch_kept: assert property (@(posedge clk) disable iff (rst)
    (pop && !lat_we) |=> $stable(lat));

  // R10: with no request the counter holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !(step || skip || jump || call || ret || irq_ack || pcl_we) |=> $stable(fetch_addr));
endmodule

// File: tb/sim_pc_seq.sv
`timescale 1ns/1ps
module sim_pc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 0, skip = 0, jump = 0, call = 0, ret = 0, irq_ack = 0;
  logic        pcl_we = 0, lat_we = 0;
  logic [10:0] target = '0;
  logic [7:0]  pcl_wdata = '0;
  logic [4:0]  lat_wdata = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pcl_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [12:0] m_pc;
  logic [4:0]  m_lat;
  logic [12:0] m_stk [8];
  logic [2:0]  m_ptr;
  int          m_valid;

  always #2 clk = ~clk;

  pc_seq u0 (
    .clk(clk), .rst(rst), .step(step), .skip(skip), .jump(jump), .call(call),
    .target(target), .ret(ret), .irq_ack(irq_ack), .pcl_we(pcl_we),
    .pcl_wdata(pcl_wdata), .lat_we(lat_we), .lat_wdata(lat_wdata),
    .fetch_addr(fetch_addr), .pcl_rd(pcl_rd)
  );

  task automatic check(input string tag, input logic [12:0] exp);
    checks++;
    if (fetch_addr !== exp) begin
      errors++;
      $display("FAIL %s fetch_addr actual=%h expected=%h", tag, fetch_addr, exp);
    end
    checks++;
    if (pcl_rd !== exp[7:0]) begin  // R11
      errors++;
      $display("FAIL R11 pcl_rd actual=%h expected=%h", pcl_rd, exp[7:0]);
    end
  endtask

  // Applies one cycle of requests, advances the model, checks after the edge
  task automatic cyc(input logic a, input logic s, input logic p, input logic j,
                     input logic c, input logic r, input logic i,
                     input logic [7:0] wd, input logic [10:0] tg,
                     input logic lw, input logic [4:0] ld, input string tag_in);
    string tag;
    int nreq;
    step = a; skip = s; pcl_we = p; jump = j; call = c; ret = r; irq_ack = i;
    pcl_wdata = wd; target = tg; lat_we = lw; lat_wdata = ld;
    nreq = a + s + p + j + c + r + i;
    // reference, priority per R10
    if (i) begin
      tag = "R8"; m_stk[m_ptr] = m_pc; m_ptr++; m_pc = 13'h0004;
      m_valid = (m_valid < 8) ? m_valid + 1 : 8;
    end else if (r) begin
      tag = "R7"; m_ptr--; m_pc = m_stk[m_ptr]; m_valid--;
    end else if (c) begin
      tag = "R6"; m_stk[m_ptr] = m_pc + 13'd1; m_ptr++;
      m_pc = {m_lat[4:3], tg}; m_valid = (m_valid < 8) ? m_valid + 1 : 8;
    end else if (j) begin
      tag = "R5"; m_pc = {m_lat[4:3], tg};
    end else if (p) begin
      tag = "R4"; m_pc = {m_lat, wd};
    end else if (s) begin
      tag = "R3"; m_pc = m_pc + 13'd2;
    end else if (a) begin
      tag = "R2"; m_pc = m_pc + 13'd1;
    end else tag = "R10";
    if (nreq > 1) tag = "R10";
    if (tag_in != "") tag = tag_in;
    if (lw) m_lat = ld;  // R12: latch updates after this cycle's use
    @(negedge clk);
    check(tag, m_pc);
  endtask

  task automatic idle();
    cyc(0,0,0,0,0,0,0, 8'h00, 11'h000, 0, 5'h00, "");
  endtask

  task automatic do_reset();
    rst = 1;
    step = 0; skip = 0; pcl_we = 0; jump = 0; call = 0; ret = 0; irq_ack = 0; lat_we = 0;
    repeat (2) @(negedge clk);
    m_pc = 13'h0000; m_lat = 5'h00; m_ptr = 3'd0; m_valid = 0;
    check("R1", 13'h0000);
    rst = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] rets [9];
    int seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();

    // R1: latch cleared -> low-byte write gives upper bits 0
    cyc(0,0,1,0,0,0,0, 8'hA5, 11'h000, 0, 5'h00, "R1");
    // R2 / R4: wrap at top of space
    cyc(0,0,0,0,0,0,0, 8'h00, 11'h000, 1, 5'h1F, "R12");
    cyc(0,0,1,0,0,0,0, 8'hFF, 11'h000, 0, 5'h00, "R4");
    cyc(1,0,0,0,0,0,0, 8'h00, 11'h000, 0, 5'h00, "R2");
    // R3: skip wraps from 1FFEh and 1FFFh
    cyc(0,0,1,0,0,0,0, 8'hFE, 11'h000, 0, 5'h00, "R4");
    cyc(0,1,0,0,0,0,0, 8'h00, 11'h000, 0, 5'h00, "R3");
    cyc(0,0,1,0,0,0,0, 8'hFF, 11'h000, 0, 5'h00, "R4");
    cyc(0,1,0,0,0,0,0, 8'h00, 11'h000, 0, 5'h00, "R3");
    // R12: latch write with same-cycle low-byte write uses the old latch
    cyc(0,0,1,0,0,0,0, 8'h12, 11'h000, 1, 5'h03, "R12");
    // R5: jump uses latch bits 4:3 (latch=00011 -> upper 00)
    cyc(0,0,0,1,0,0,0, 8'h00, 11'h7AB, 1, 5'h10, "R5");
    cyc(0,0,0,1,0,0,0, 8'h00, 11'h123, 0, 5'h00, "R5");
    // R8 then R7: interrupt push and return
    cyc(0,0,0,0,0,0,1, 8'h00, 11'h000, 0, 5'h00, "R8");
    cyc(0,0,0,0,0,1,0, 8'h00, 11'h000, 0, 5'h00, "R7");
    // R7: latch unchanged across return -> next pcl write still uses 10000b
    cyc(0,0,0,0,1,0,0, 8'h00, 11'h055, 0, 5'h00, "R6");
    cyc(0,0,0,0,0,1,0, 8'h00, 11'h000, 0, 5'h00, "R7");
    cyc(0,0,1,0,0,0,0, 8'h3C, 11'h000, 0, 5'h00, "R7");
    // R10: all requests at once -> interrupt wins; then ret beats call
    cyc(1,1,1,1,1,0,1, 8'h77, 11'h222, 0, 5'h00, "R10");
    cyc(1,1,1,1,1,1,0, 8'h77, 11'h222, 0, 5'h00, "R10");
    idle();
    // R9: nine nested calls, eight returns come back as calls 9..2
    for (int k = 0; k < 9; k++) begin
      rets[k] = {m_lat[4:3], 11'(k * 16 + 3)} + 13'd0;
      cyc(0,0,0,0,1,0,0, 8'h00, 11'(k * 16 + 3), 0, 5'h00, "R9");
    end
    for (int k = 0; k < 8; k++) begin
      cyc(0,0,0,0,0,1,0, 8'h00, 11'h000, 0, 5'h00, "R9");
      // expected: return address of call (8-k) is target of call (7-k) + 1
      checks++;
      if (fetch_addr !== 13'(rets[7 - k] + 13'd1)) begin
        errors++;
        $display("FAIL R9 ring pop actual=%h expected=%h", fetch_addr, 13'(rets[7 - k] + 13'd1));
      end
    end

    do_reset();
    // constrained random, mixed with multi-request cycles
    for (int n = 0; n < 4000; n++) begin
      logic a, s, p, j, c, r, i, lw;
      int sel;
      a = 0; s = 0; p = 0; j = 0; c = 0; r = 0; i = 0;
      sel = $urandom % 100;
      if (sel < 30) a = 1;
      else if (sel < 40) s = 1;
      else if (sel < 50) p = 1;
      else if (sel < 58) j = 1;
      else if (sel < 70) c = 1;
      else if (sel < 84) r = 1;
      else if (sel < 89) i = 1;
      else if (sel < 97) begin
        a = 1'($urandom); s = 1'($urandom); p = 1'($urandom);
        j = 1'($urandom); c = 1'($urandom); r = 1'($urandom);
      end
      if (m_valid == 0) r = 0;
      lw = ($urandom % 5) == 0;
      cyc(a, s, p, j, c, r, i, 8'($urandom), 11'($urandom), lw, 5'($urandom), "");
      if (($urandom % 1000) == 0) do_reset();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule